// File: doc/BRIEF.md
# Sub-register merging general-purpose register file

This block is the integer register file of an execution core. It holds sixteen 64-bit registers and has two combinational read ports and one write port. Every register is an ordinary storage cell. No register has a role fixed in hardware, and any register may hold any 64-bit value.

Each write carries a two-bit size code. The size code decides how the incoming data combines with the value already in the destination register:

- A full-width write replaces the whole register.
- A 32-bit write stores the low word and clears the upper word.
- A 16-bit write merges into the old value, so every bit above the written field keeps its previous value.
- An 8-bit write merges in the same way.

Every register index has four bits. The index is a 3-bit base field with one extension bit added as its most significant bit. The upper eight registers can therefore only be reached when the extension bit is set. Reads always return all 64 bits. A read issued in the same cycle as a write to the same register returns the value from before the write.

Top module: `gpr_file`

## Requirements
- R1: A synchronous reset, active low and sampled at the rising clock edge, clears all sixteen registers to zero. Both read ports then return zero for every index.
- R2: A write with size code 2'b11 replaces all 64 bits of the destination register with the write data.
- R3: A write with size code 2'b10 stores write data bits 31:0 into bits 31:0 of the destination and forces bits 63:32 to zero.
- R4: A write with size code 2'b01 stores write data bits 15:0 into bits 15:0 of the destination and leaves bits 63:16 unchanged.
- R5: A write with size code 2'b00 stores write data bits 7:0 into bits 7:0 of the destination and leaves bits 63:8 unchanged.
- R6: Every register index is {extension bit, 3-bit base}. When the extension bit is 0, the access reaches registers 0 to 7. When it is 1, the access reaches registers 8 to 15.
- R7: While the write enable is low, no register changes, whatever the other write inputs are.
- R8: Reads are combinational. A read of the register being written in the same cycle returns the old value, and the new value is visible from the cycle after the clock edge.
- R9: The two read ports are independent, and both may address the same register at once and return the same value.
- R10: A write changes only the register it addresses. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write enable |
| wr_ext | input | 1 | Write index extension bit (index MSB) |
| wr_base | input | 3 | Write index base field |
| wr_size | input | 2 | Write size: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits |
| wr_data | input | 64 | Write data, right-aligned |
| rd_a_ext | input | 1 | Read port A extension bit |
| rd_a_base | input | 3 | Read port A base field |
| rd_b_ext | input | 1 | Read port B extension bit |
| rd_b_base | input | 3 | Read port B base field |
| rd_a_data | output | 64 | Read port A data |
| rd_b_data | output | 64 | Read port B data |

## Verification
The bench aims at the size-dependent writeback corner cases:

- It follows a 16-bit or 8-bit write with a read of a register whose upper bits were set earlier. A design that zero-extended narrow writes would lose those bits.
- It issues a 32-bit write over a full-width value. A design that merged instead of clearing would leave stale upper bits.
- It writes two registers that differ only in the extension bit. This catches a dropped or mis-placed extension bit, which would alias register 13 onto register 5.
- It reads the destination register in the same cycle as its write. A design with a bypass, or with reads taken from the registered state after the edge, would return the new value one cycle early.

// File: rtl/gpr_pkg.sv
// Package: shared types and width helpers for the register file.
// Assumes the data width is a multiple of 64 so each narrow lane divides evenly.
package gpr_pkg;

    // Write size codes, encoded as the size field of the write port
    typedef enum logic [1:0] {
        WSZ_8  = 2'b00,
        WSZ_16 = 2'b01,
        WSZ_32 = 2'b10,
        WSZ_64 = 2'b11
    } wsize_e;

endpackage

// File: rtl/gpr_index_join.sv
// Module: gpr_index_join
// Forms the full register index by placing the extension bit above the base field.
// Assumes the register count is exactly 2**(BASE_W+1).
module gpr_index_join #(
    parameter int BASE_W = 3
) (
    input  logic              ext,
    input  logic [BASE_W-1:0] base,
    output logic [BASE_W:0]   idx
);

    // Concatenate extension bit as the MSB
    assign idx = {ext, base};

endmodule

// File: rtl/gpr_merge.sv
// Module: gpr_merge
// Combines write data with the old register value according to the size code.
// A 32-bit write clears the upper half, while narrower writes keep every bit above the field.
// Assumes XLEN is a multiple of 64.
module gpr_merge
    import gpr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] new_val,
    input  wsize_e          size,
    output logic [XLEN-1:0] merged
);

    localparam int W8  = XLEN / 8;
    localparam int W16 = XLEN / 4;
    localparam int W32 = XLEN / 2;

    // Select the merge rule for the requested size
    always_comb begin
        merged = old_val;
        unique case (size)
            WSZ_8:  merged = {old_val[XLEN-1:W8],  new_val[W8-1:0]};
            WSZ_16: merged = {old_val[XLEN-1:W16], new_val[W16-1:0]};
            WSZ_32: merged = {{(XLEN-W32){1'b0}},  new_val[W32-1:0]};
            WSZ_64: merged = new_val;
            default: merged = old_val;
        endcase
    end

endmodule

// File: rtl/gpr_bank.sv
// Module: gpr_bank
// Storage for NREG registers, exposed as a flat vector.
// Assumes the value presented is already merged and that only the addressed entry loads it.
module gpr_bank #(
    parameter int XLEN  = 64,
    parameter int NREG  = 16,
    parameter int IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wen,
    input  logic [IDX_W-1:0]     widx,
    input  logic [XLEN-1:0]      wval,
    output logic [NREG*XLEN-1:0] flat
);

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        logic [XLEN-1:0] q;
        logic            hit;

        // Decode whether this entry is the write target
        assign hit = wen && (widx == IDX_W'(g));

        // Hold or load the entry, clearing it on reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (hit)
                q <= wval;
        end

        assign flat[g*XLEN +: XLEN] = q;
    end

endmodule

// File: rtl/gpr_read_mux.sv
// Module: gpr_read_mux
// Combinational selection of one register from the flat storage vector.
// Assumes the index range covers all NREG entries.
module gpr_read_mux #(
    parameter int XLEN  = 64,
    parameter int NREG  = 16,
    parameter int IDX_W = 4
) (
    input  logic [NREG*XLEN-1:0] flat,
    input  logic [IDX_W-1:0]     idx,
    output logic [XLEN-1:0]      data
);

    // Pick the addressed entry
    always_comb begin
        data = '0;
        for (int i = 0; i < NREG; i++)
            if (idx == IDX_W'(i))
                data = flat[i*XLEN +: XLEN];
    end

endmodule

// File: rtl/gpr_file.sv
// Module: gpr_file
// 16 x 64-bit register file with two read ports and one size-aware write port.
// Indices are {extension bit, base field}. Reads are combinational and do not bypass.
// Assumes a single clock domain and a synchronous active-low reset.
module gpr_file
    import gpr_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int BASE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_ext,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [1:0]        wr_size,
    input  logic [XLEN-1:0]   wr_data,
    input  logic              rd_a_ext,
    input  logic [BASE_W-1:0] rd_a_base,
    input  logic              rd_b_ext,
    input  logic [BASE_W-1:0] rd_b_base,
    output logic [XLEN-1:0]   rd_a_data,
    output logic [XLEN-1:0]   rd_b_data
);

    localparam int IDX_W = BASE_W + 1;
    localparam int NREG  = 1 << IDX_W;
    localparam int NRD   = 2;

    logic [NREG*XLEN-1:0] flat;
    logic [IDX_W-1:0]     w_idx;
    logic [XLEN-1:0]      w_old;
    logic [XLEN-1:0]      w_merged;
    wsize_e               w_size;

    logic              rd_ext  [NRD];
    logic [BASE_W-1:0] rd_base [NRD];
    logic [XLEN-1:0]   rd_data [NRD];

    // Gather read port inputs into arrays
    assign rd_ext[0]  = rd_a_ext;
    assign rd_base[0] = rd_a_base;
    assign rd_ext[1]  = rd_b_ext;
    assign rd_base[1] = rd_b_base;
    assign rd_a_data  = rd_data[0];
    assign rd_b_data  = rd_data[1];

    // Interpret the raw size field
    assign w_size = wsize_e'(wr_size);

    gpr_index_join #(.BASE_W(BASE_W)) u_widx (
        .ext (wr_ext),
        .base(wr_base),
        .idx (w_idx)
    );

    gpr_read_mux #(.XLEN(XLEN), .NREG(NREG), .IDX_W(IDX_W)) u_old (
        .flat(flat),
        .idx (w_idx),
        .data(w_old)
    );

    gpr_merge #(.XLEN(XLEN)) u_merge (
        .old_val(w_old),
        .new_val(wr_data),
        .size   (w_size),
        .merged (w_merged)
    );

    gpr_bank #(.XLEN(XLEN), .NREG(NREG), .IDX_W(IDX_W)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .wen  (wr_en),
        .widx (w_idx),
        .wval (w_merged),
        .flat (flat)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [IDX_W-1:0] idx;

        gpr_index_join #(.BASE_W(BASE_W)) u_ridx (
            .ext (rd_ext[p]),
            .base(rd_base[p]),
            .idx (idx)
        );

        gpr_read_mux #(.XLEN(XLEN), .NREG(NREG), .IDX_W(IDX_W)) u_rmux (
            .flat(flat),
            .idx (idx),
            .data(rd_data[p])
        );
    end

endmodule

// File: rtl/gpr_file_chk.sv
// Module: gpr_file_chk
// Port-level temporal checks for gpr_file, attached by bind.
// Assumes read port B, when it addresses the write target, shows the pre-write value.
module gpr_file_chk #(
    parameter int XLEN   = 64,
    parameter int BASE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_ext,
    input logic [BASE_W-1:0] wr_base,
    input logic [1:0]        wr_size,
    input logic [XLEN-1:0]   wr_data,
    input logic              rd_a_ext,
    input logic [BASE_W-1:0] rd_a_base,
    input logic              rd_b_ext,
    input logic [BASE_W-1:0] rd_b_base,
    input logic [XLEN-1:0]   rd_a_data,
    input logic [XLEN-1:0]   rd_b_data
);

    localparam int W8  = XLEN / 8;
    localparam int W16 = XLEN / 4;
    localparam int W32 = XLEN / 2;

    logic [BASE_W:0] wi, ra, rb;

    // Full indices as seen at the ports
    assign wi = {wr_ext, wr_base};
    assign ra = {rd_a_ext, rd_a_base};
    assign rb = {rd_b_ext, rd_b_base};

    // R2
    full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'b11) |=>
        (ra != $past(wi)) || (rd_a_data == $past(wr_data)));

    // R3
    word_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'b10) |=>
        (ra != $past(wi)) ||
        (rd_a_data == {{(XLEN-W32){1'b0}}, $past(wr_data[W32-1:0])}));

    // R4
    half_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'b01 && rb == wi) |=>
        (ra != $past(wi)) ||
        (rd_a_data == {$past(rd_b_data[XLEN-1:W16]), $past(wr_data[W16-1:0])}));

    // R5
    byte_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'b00 && rb == wi) |=>
        (ra != $past(wi)) ||
        (rd_a_data == {$past(rd_b_data[XLEN-1:W8]), $past(wr_data[W8-1:0])}));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (ra != $past(ra)) || (rd_a_data == $past(rd_a_data)));

    // R10
    other_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ra != wi) |=> (ra != $past(ra)) || (rd_a_data == $past(rd_a_data)));

endmodule

bind gpr_file gpr_file_chk #(.XLEN(XLEN), .BASE_W(BASE_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_ext   (wr_ext),
    .wr_base  (wr_base),
    .wr_size  (wr_size),
    .wr_data  (wr_data),
    .rd_a_ext (rd_a_ext),
    .rd_a_base(rd_a_base),
    .rd_b_ext (rd_b_ext),
    .rd_b_base(rd_b_base),
    .rd_a_data(rd_a_data),
    .rd_b_data(rd_b_data)
);

// File: tb/gpr_file_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference array compared against both read ports every cycle.
module gpr_file_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_ext = 1'b0;
    logic [2:0]  wr_base = '0;
    logic [1:0]  wr_size = '0;
    logic [63:0] wr_data = '0;
    logic        rd_a_ext = 1'b0;
    logic [2:0]  rd_a_base = '0;
    logic        rd_b_ext = 1'b0;
    logic [2:0]  rd_b_base = '0;
    logic [63:0] rd_a_data, rd_b_data;

    int checks = 0;
    int fails  = 0;
    logic [63:0] ref_q [16];
    string       last_tag [16];

    // 50 MHz clock
    always #10 clk = ~clk;

    gpr_file dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_ext(wr_ext), .wr_base(wr_base),
        .wr_size(wr_size), .wr_data(wr_data),
        .rd_a_ext(rd_a_ext), .rd_a_base(rd_a_base),
        .rd_b_ext(rd_b_ext), .rd_b_base(rd_b_base),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data)
    );

    // Requirement-level merge rule, written from the size table
    function automatic logic [63:0] ref_merge(logic [63:0] old, logic [63:0] d, logic [1:0] sz);
        logic [63:0] r;
        r = old;
        case (sz)
            2'b00: r[7:0]  = d[7:0];
            2'b01: r[15:0] = d[15:0];
            2'b10: r = {32'h0, d[31:0]};
            default: r = d;
        endcase
        return r;
    endfunction

    function automatic string size_tag(logic [1:0] sz);
        case (sz)
            2'b00: return "R5";
            2'b01: return "R4";
            2'b10: return "R3";
            default: return "R2";
        endcase
    endfunction

    task automatic compare(string tag, string port, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s port %s: actual %h expected %h", tag, port, got, exp);
        end
    endtask

    // One cycle: drive at negedge, check pre-edge reads, update model at the edge
    task automatic step(logic en, logic [3:0] wi, logic [1:0] sz, logic [63:0] d,
                        logic [3:0] ia, logic [3:0] ib, string tag);
        @(negedge clk);
        wr_en = en; {wr_ext, wr_base} = wi; wr_size = sz; wr_data = d;
        {rd_a_ext, rd_a_base} = ia; {rd_b_ext, rd_b_base} = ib;
        #2;
        compare(tag == "" ? last_tag[ia] : tag, "A", rd_a_data, ref_q[ia]);
        compare(tag == "" ? last_tag[ib] : tag, "B", rd_b_data, ref_q[ib]);
        @(posedge clk);
        if (en) begin
            ref_q[wi] = ref_merge(ref_q[wi], d, sz);
            last_tag[wi] = size_tag(sz);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b1; wr_data = '1; wr_size = 2'b11;
        repeat (2) @(posedge clk);
        for (int i = 0; i < 16; i++) begin
            ref_q[i] = '0;
            last_tag[i] = "R1";
        end
        @(negedge clk);
        rst_n = 1'b1; wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: every register reads zero after reset
        for (int i = 0; i < 8; i++) step(1'b0, 4'd0, 2'b11, '0, 4'(i), 4'(i + 8), "R1");

        // R2 full write
        step(1'b1, 4'd3, 2'b11, 64'hDEAD_BEEF_0123_4567, 4'd3, 4'd3, "");
        step(1'b0, 4'd0, 2'b11, '0, 4'd3, 4'd4, "R2");
        // R3 32-bit write clears upper half
        step(1'b1, 4'd3, 2'b10, 64'hFFFF_FFFF_89AB_CDEF, 4'd0, 4'd0, "");
        step(1'b0, 4'd0, 2'b11, '0, 4'd3, 4'd3, "R3");
        // R4 16-bit merge keeps upper bits
        step(1'b1, 4'd3, 2'b11, 64'h1122_3344_5566_7788, 4'd0, 4'd0, "");
        step(1'b1, 4'd3, 2'b01, 64'hFFFF_FFFF_FFFF_A5A5, 4'd0, 4'd0, "");
        step(1'b0, 4'd0, 2'b11, '0, 4'd3, 4'd3, "R4");
        // R5 8-bit merge keeps upper bits
        step(1'b1, 4'd3, 2'b00, 64'hFFFF_FFFF_FFFF_FF3C, 4'd0, 4'd0, "");
        step(1'b0, 4'd0, 2'b11, '0, 4'd3, 4'd3, "R5");
        // R6 extension bit selects the upper bank
        step(1'b1, 4'd5,  2'b11, 64'h0505_0505_0505_0505, 4'd0, 4'd0, "");
        step(1'b1, 4'd13, 2'b11, 64'h1313_1313_1313_1313, 4'd0, 4'd0, "");
        step(1'b0, 4'd0, 2'b11, '0, 4'd5, 4'd13, "R6");
        // R7 write enable low changes nothing
        step(1'b0, 4'd5, 2'b11, 64'hBAD0_BAD0_BAD0_BAD0, 4'd5, 4'd13, "R7");
        step(1'b0, 4'd0, 2'b11, '0, 4'd5, 4'd13, "R7");
        // R8 same-cycle read returns old value, new value next cycle
        step(1'b1, 4'd7, 2'b11, 64'h7777_0000_7777_0000, 4'd7, 4'd7, "R8");
        step(1'b0, 4'd0, 2'b11, '0, 4'd7, 4'd0, "R8");
        // R9 both ports on one register
        step(1'b0, 4'd0, 2'b11, '0, 4'd13, 4'd13, "R9");
        // R10 neighbours untouched
        step(1'b1, 4'd4, 2'b11, 64'h4444_4444_4444_4444, 4'd0, 4'd0, "");
        step(1'b0, 4'd0, 2'b11, '0, 4'd3, 4'd5, "R10");

        // Random mixed-size traffic
        for (int n = 0; n < 4000; n++)
            step(1'($urandom), 4'($urandom), 2'($urandom),
                 {$urandom, $urandom}, 4'($urandom), 4'($urandom), "");

        // R1 again after traffic
        do_reset();
        for (int i = 0; i < 8; i++) step(1'b0, 4'd0, 2'b11, '0, 4'(i), 4'(i + 8), "R1");

        finish_run();
    end

endmodule